// File: doc/BRIEF.md
# Accumulating Scanline Bar Compositor

This block keeps one short line buffer that a video fetch reads on every visible scanline. Between lines, a plot request paints one bar into that buffer at a horizontal position. The bar is merged into what is already there, so the line shown at row N is the stack of every bar drawn since the start of the frame. Nothing erases a bar once it is drawn, except a frame-start clear issued during vertical blanking.

A bar covers four buffer bytes spaced one character stride apart. Every byte carries two interleaved pixels. The lowest bit of the position picks the bar's alignment. An even position gives a left-aligned bar, whose last byte keeps the existing right pixel. An odd position gives a right-aligned bar, whose first byte keeps the existing left pixel. The colours run in a fixed gradient from bright to blue. Both alignments take the same number of cycles, so each scanline's update always finishes at the same point in the line.

Top module: `kbar_compositor`

## Requirements
- R1: After reset every buffer byte reads 0x00 and `plotDone` is low.
- R2: Pixel codes are 4 bits. In a byte, the left pixel sits in the odd bits (bit 2i+1 = code bit i) and the right pixel sits in the even bits (bit 2i = code bit i). The base byte is X>>1, and the bar bytes are base+0, base+8, base+16 and base+24.
- R3: Even X (left-aligned) writes 0x2F, 0x2C and 0x23 to the first three bar bytes. The fourth byte becomes (old & 0x55) | 0x20.
- R4: Odd X (right-aligned) sets the first bar byte to (old & 0xAA) | 0x15. The other three bar bytes become 0x1E, 0x19 and 0x12.
- R5: Bytes outside the current bar keep their contents, so bars accumulate from one plot to the next.
- R6: Bar bytes at address 80 or above are not written. A read of address 80 or above returns 0x00.
- R7: A high `clearStrobe` sets all 80 bytes to 0x00 at the next edge. It also cancels any plot in progress, so that plot raises no `plotDone`.
- R8: An accepted plot writes its four bytes on the four edges that follow the accepting edge, one byte per edge. `plotDone` is a one-cycle pulse after the fourth write. This timing is the same for both parities.
- R9: A `plotValid` that arrives while a plot is in progress is ignored.
- R10: The read port has one cycle of latency. A read of a byte on the same edge that byte is written returns the old value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| plotValid | input | 1 | Request to paint one bar |
| plotX | input | 8 | Horizontal bar position; bit 0 selects alignment |
| clearStrobe | input | 1 | Frame-start clear of the whole buffer |
| rdAddr | input | 7 | Display fetch byte address |
| rdData | output | 8 | Fetched byte, one cycle after the address |
| plotDone | output | 1 | Pulse when a bar has been fully merged |

## Verification
Every position from 0 to 255 is plotted in turn. The buffer is cleared every 32 plots, so odd and even bars land on top of one another. This separates the keep masks of the two alignments, and it shows whether untouched bytes survive. Positions from 112 upward push some or all bar bytes past the end of the buffer, which exercises write suppression. Directed sequences cover three cases: a request during a busy plot, a clear in the middle of a plot, and a display read of the byte being rewritten in the same cycle, which must return the pre-write value.

// File: rtl/kbar_pkg.sv
package kbar_pkg;
  localparam int BAR_BYTES = 4;
  localparam int SLOT_W    = $clog2(BAR_BYTES);
  localparam int BASE_W    = 8;

  typedef struct packed {
    logic              wrEn;
    logic              clear;
    logic [SLOT_W-1:0] slot;
    logic              rightAlign;
    logic [BASE_W-1:0] base;
  } strobe_t;

  // interleave two 4-bit pixel codes: left in odd bits, right in even bits
  function automatic logic [7:0] pixPair(input logic [3:0] l, input logic [3:0] r);
    logic [7:0] b;
    for (int i = 0; i < 4; i++) begin
      b[2*i+1] = l[i];
      b[2*i]   = r[i];
    end
    return b;
  endfunction

  function automatic logic [7:0] barPattern(input logic [SLOT_W-1:0] slot, input logic right);
    logic [3:0] s;
    s = 4'(slot);
    if (!right) begin
      if (int'(slot) == BAR_BYTES-1) return pixPair(4'd4, 4'd0);
      return pixPair(4'd7 - s, 4'd3 - s);
    end
    if (slot == '0) return pixPair(4'd0, 4'd7);
    return pixPair(4'd4 - s, 4'd7 - s);
  endfunction

  function automatic logic [7:0] keepMask(input logic [SLOT_W-1:0] slot, input logic right);
    if (!right && int'(slot) == BAR_BYTES-1) return 8'h55;
    if (right && slot == '0) return 8'hAA;
    return 8'h00;
  endfunction
endpackage

// File: rtl/kbar_ctrl.sv
module kbar_ctrl
  import kbar_pkg::*;
#(
  parameter int XW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          plotValid,
  input  logic [XW-1:0] plotX,
  input  logic          clearStrobe,
  output strobe_t       st,
  output logic          plotDone
);
  localparam logic [SLOT_W-1:0] LAST = SLOT_W'(BAR_BYTES - 1);

  logic              active;
  logic [SLOT_W-1:0] step;
  logic [BASE_W-1:0] baseLat;
  logic              rightLat;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      active   <= 1'b0;
      step     <= '0;
      baseLat  <= '0;
      rightLat <= 1'b0;
      plotDone <= 1'b0;
    end else begin
      plotDone <= 1'b0;
      if (clearStrobe) begin
        active <= 1'b0;
        step   <= '0;
      end else if (active) begin
        if (step == LAST) begin
          active   <= 1'b0;
          step     <= '0;
          plotDone <= 1'b1;
        end else begin
          step <= step + 1'b1;
        end
      end else if (plotValid) begin
        active   <= 1'b1;
        step     <= '0;
        baseLat  <= BASE_W'(plotX >> 1);
        rightLat <= plotX[0];
      end
    end
  end

  always_comb begin
    st.wrEn       = active && !clearStrobe;
    st.clear      = clearStrobe;
    st.slot       = step;
    st.rightAlign = rightLat;
    st.base       = baseLat;
  end

  // R9
  xhold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (active && !clearStrobe) |=> ($stable(baseLat) && $stable(rightLat)));

  // R8
  slot_seq_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (active && !clearStrobe && step != LAST) |=> (active && step == $past(step) + 1'b1));

  // R8
  done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    plotDone |=> !plotDone);

  // R7
  clear_abort_chk: assert property (@(posedge clk) disable iff (!rst_n)
    clearStrobe |=> (!active && !plotDone));
endmodule

// File: rtl/kbar_datapath.sv
module kbar_datapath
  import kbar_pkg::*;
#(
  parameter int BUF_BYTES = 80,
  parameter int STRIDE    = 8,
  localparam int AW       = $clog2(BUF_BYTES)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  strobe_t       st,
  input  logic [AW-1:0] rdAddr,
  output logic [7:0]    rdData
);
  logic [7:0]  mem [BUF_BYTES];
  logic [15:0] wrAddr;
  logic        inRange;
  logic [AW-1:0] wrIdx;
  logic [7:0]  newByte;

  always_comb begin
    wrAddr  = 16'(st.base) + 16'(st.slot) * 16'(STRIDE);
    inRange = wrAddr < 16'(BUF_BYTES);
    wrIdx   = AW'(wrAddr);
    newByte = (mem[wrIdx] & keepMask(st.slot, st.rightAlign))
            | barPattern(st.slot, st.rightAlign);
  end

  always_ff @(posedge clk) begin
    if (!rst_n || st.clear) begin
      for (int i = 0; i < BUF_BYTES; i++) mem[i] <= 8'h00;
    end else if (st.wrEn && inRange) begin
      mem[wrIdx] <= newByte;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) rdData <= 8'h00;
    else if (32'(rdAddr) < BUF_BYTES) rdData <= mem[rdAddr];
    else rdData <= 8'h00;
  end

  // R6
  oob_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (32'(rdAddr) >= BUF_BYTES) |=> (rdData == 8'h00));

  for (genvar g = 0; g < BUF_BYTES; g++) begin : g_clr
    // R7
    clr_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
      st.clear |=> (mem[g] == 8'h00));
  end
endmodule

// File: rtl/kbar_compositor.sv
module kbar_compositor
  import kbar_pkg::*;
#(
  parameter int XW        = 8,
  parameter int BUF_BYTES = 80,
  parameter int STRIDE    = 8,
  localparam int AW       = $clog2(BUF_BYTES)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          plotValid,
  input  logic [XW-1:0] plotX,
  input  logic          clearStrobe,
  input  logic [AW-1:0] rdAddr,
  output logic [7:0]    rdData,
  output logic          plotDone
);
  strobe_t st;

  kbar_ctrl #(.XW(XW)) u_ctrl (
    .clk(clk), .rst_n(rst_n), .plotValid(plotValid), .plotX(plotX),
    .clearStrobe(clearStrobe), .st(st), .plotDone(plotDone)
  );

  kbar_datapath #(.BUF_BYTES(BUF_BYTES), .STRIDE(STRIDE)) u_dp (
    .clk(clk), .rst_n(rst_n), .st(st), .rdAddr(rdAddr), .rdData(rdData)
  );
endmodule

// File: tb/kbar_compositor_bench.sv
`timescale 1ns/1ps
module kbar_compositor_bench;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       plotValid = 1'b0;
  logic [7:0] plotX = 8'h00;
  logic       clearStrobe = 1'b0;
  logic [6:0] rdAddr = 7'h00;
  logic [7:0] rdData;
  logic       plotDone;

  int tests = 0;
  int fails = 0;
  bit finished = 1'b0;
  logic [7:0] model [80];

  always #10 clk = ~clk;

  kbar_compositor u_kbar_compositor (
    .clk(clk), .rst_n(rst_n), .plotValid(plotValid), .plotX(plotX),
    .clearStrobe(clearStrobe), .rdAddr(rdAddr), .rdData(rdData), .plotDone(plotDone)
  );

  task automatic check(input bit ok, input string req, input int act, input int exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
    end
  endtask

  task automatic readByte(input int a, output logic [7:0] v);
    @(negedge clk);
    rdAddr = 7'(a);
    @(negedge clk);
    v = rdData;
  endtask

  // R2/R3/R4 literal byte values from the requirements
  function automatic logic [7:0] pat(input bit right, input int s);
    if (!right) case (s) 0: return 8'h2F; 1: return 8'h2C; 2: return 8'h23; default: return 8'h20; endcase
    else case (s) 0: return 8'h15; 1: return 8'h1E; 2: return 8'h19; default: return 8'h12; endcase
  endfunction
  function automatic logic [7:0] keep(input bit right, input int s);
    if (!right && s == 3) return 8'h55;
    if (right && s == 0) return 8'hAA;
    return 8'h00;
  endfunction

  task automatic modelPlot(input int x);
    int b = x >> 1;
    bit r = x[0];
    for (int s = 0; s < 4; s++) begin
      int a = b + 8 * s;
      if (a < 80) model[a] = (model[a] & keep(r, s)) | pat(r, s);
    end
  endtask

  task automatic checkBuffer(input string req);
    logic [7:0] v;
    for (int i = 0; i < 80; i++) begin
      readByte(i, v);
      check(v == model[i], req, v, model[i]);
    end
    for (int i = 80; i < 84; i++) begin
      readByte(i, v);
      check(v == 8'h00, "R6 out-of-range read", v, 0);
    end
  endtask

  task automatic doClear();
    @(negedge clk);
    clearStrobe = 1'b1;
    @(negedge clk);
    clearStrobe = 1'b0;
    for (int i = 0; i < 80; i++) model[i] = 8'h00;
  endtask

  // R8: plotDone expected on the fifth falling edge after driving the request
  task automatic doPlot(input int x);
    int seenAt = 0;
    @(negedge clk);
    plotValid = 1'b1;
    plotX = 8'(x);
    for (int k = 1; k <= 7; k++) begin
      @(negedge clk);
      plotValid = 1'b0;
      if (plotDone && seenAt == 0) seenAt = k;
    end
    check(seenAt == 5, x[0] ? "R8 done latency right" : "R8 done latency left", seenAt, 5);
    modelPlot(x);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      fails++;
      tests++;
      $display("FAIL watchdog actual=0x0 expected=0x1");
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  initial begin
    logic [7:0] v;
    for (int i = 0; i < 80; i++) model[i] = 8'h00;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    // R1
    check(plotDone == 1'b0, "R1 plotDone after reset", plotDone, 0);
    checkBuffer("R1 reset contents");

    // R2 R3 R4 R5 R6: sweep every position, clearing every 32 plots
    for (int x = 0; x < 256; x++) begin
      if (x % 32 == 0) begin
        doClear();
        checkBuffer("R7 cleared buffer");
      end
      doPlot(x);
      checkBuffer(x[0] ? "R4 R5 right bar merge" : "R3 R5 left bar merge");
    end

    // R9: request during busy plot ignored
    doClear();
    @(negedge clk);
    plotValid = 1'b1; plotX = 8'd10;
    @(negedge clk);
    plotX = 8'd51;
    begin
      int dones = 0;
      for (int k = 2; k <= 14; k++) begin
        @(negedge clk);
        plotValid = 1'b0;
        if (plotDone) dones++;
      end
      check(dones == 1, "R9 single done for busy request", dones, 1);
    end
    modelPlot(10);
    checkBuffer("R9 busy request ignored");

    // R10: read of byte written on the same edge returns old value
    doClear();
    doPlot(4);
    @(negedge clk);
    plotValid = 1'b1; plotX = 8'd5;
    rdAddr = 7'd2;
    @(negedge clk);
    plotValid = 1'b0;
    @(negedge clk);
    check(rdData == 8'h2F, "R10 read during write old value", rdData, 8'h2F);
    @(negedge clk);
    check(rdData == 8'h3F, "R10 read after write new value", rdData, 8'h3F);
    repeat (4) @(negedge clk);
    modelPlot(5);
    checkBuffer("R10 buffer after overlap plot");

    // R7: clear mid-plot cancels the plot
    doPlot(40);
    @(negedge clk);
    plotValid = 1'b1; plotX = 8'd20;
    @(negedge clk);
    plotValid = 1'b0;
    @(negedge clk);
    clearStrobe = 1'b1;
    begin
      int dones = 0;
      for (int k = 0; k < 8; k++) begin
        @(negedge clk);
        clearStrobe = 1'b0;
        if (plotDone) dones++;
      end
      check(dones == 0, "R7 no done after cancelled plot", dones, 0);
    end
    for (int i = 0; i < 80; i++) model[i] = 8'h00;
    checkBuffer("R7 clear during plot");

    finished = 1'b1;
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule